// File: doc/BRIEF.md
# Quad DDR PSRAM Transaction Sequencer

This block runs one complete transaction on a 4-bit double-data-rate pseudo-SRAM. A request names one of five kinds: data read, data write, register read, register write or identification read. It also carries a 32-bit address and a byte count. The block then steps through a fixed recipe for that kind. The recipe lowers chip select, sends a command, sends the row half and then the column half of the address, waits through any latency cycles, and moves the data. It ends by releasing chip select and pulsing `done`.

Each internal clock cycle is one memory clock period. Every pad value is presented as two nibbles per cycle: one for the rising edge and one for the falling edge. Read bytes are rebuilt from the two nibbles sampled in a cycle and delivered as a byte stream. Write bytes are pulled from a byte stream with a take strobe. All pad-side outputs come from flops.

Top module: `psq_seq`

## Requirements
- R1: While reset is high and after it is released with no request, `cs_n` is 1 and `sck_en`, `dq_oe`, `busy`, `done`, `rd_valid` and `wr_take` are 0.
- R2: A request is taken only when `busy` is 0. A `req_valid` pulse while `busy` is 1 starts no transaction, now or later.
- R3: In the cycle after a request is taken, the outputs are still idle. The next cycle has `cs_n` low with `sck_en` low. After the last data cycle there is one more cycle with `cs_n` low and `sck_en` low. The cycle after that has `cs_n` high and a one-cycle `done`. `busy` is 1 from the cycle after acceptance through the hold cycle, and 0 in the `done` cycle, in which a new request may already be taken.
- R4: `req_kind` codes are 0 data read, 1 data write, 2 register read, 3 register write and 4 identification read. Kinds 0 to 3 send their command over two DDR cycles. The first cycle carries code 0xAA, 0x22, 0xCC or 0x66 (rising nibble = bits 7:4, falling nibble = bits 3:0). The second cycle carries 0x00.
- R5: After the command come four DDR address cycles carrying `req_addr` bytes 31:24, 23:16, 15:8 and 7:0 in that order. Each byte is split with its high nibble on the rising edge.
- R6: Data reads and data writes wait 28 dummy cycles and then move `req_len` bytes, one per cycle. A `req_len` of 0 moves one byte.
- R7: A register read waits 12 dummy cycles and moves 2 bytes.
- R8: A register write goes from the last column cycle straight to 2 data cycles, with no dummy cycle.
- R9: An identification read sends its command at single data rate: one cycle with 0xE on both edges, then one cycle with 0x0 on both edges. It then sends the address at DDR. The dummy count is 8, or 16 if `lat_strobe` is 1 at the clock edge that starts the last column cycle. It then reads 2 bytes.
- R10: `dq_oe` is 1 during command, address and write-data cycles. It is 0 during dummy cycles and read-data cycles. `dq_o_r`/`dq_o_f` are 0 whenever `dq_oe` is 0.
- R11: In each read-data cycle the block samples `{dq_i_r, dq_i_f}`. It presents that byte on `rd_data` with `rd_valid` 1 in the following cycle only.
- R12: `wr_take` is 1 for exactly one cycle per write byte, the cycle before that byte's pad cycle. The `wr_data` value held in a `wr_take` cycle appears on the pads in the next cycle, high nibble on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one memory clock period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_kind | input | 3 | Transaction kind code |
| req_addr | input | 32 | Row (31:16) and column (15:0) address |
| req_len | input | LEN_W | Byte count for data transfers |
| wr_data | input | 8 | Write byte stream |
| wr_take | output | 1 | Write byte consumed at the coming edge |
| lat_strobe | input | 1 | Memory latency indication for identification reads |
| dq_i_r | input | 4 | Pad input nibble, rising edge |
| dq_i_f | input | 4 | Pad input nibble, falling edge |
| cs_n | output | 1 | Chip select, active low |
| sck_en | output | 1 | Memory clock enable |
| dq_oe | output | 1 | Pad output enable |
| dq_o_r | output | 4 | Pad output nibble, rising edge |
| dq_o_f | output | 4 | Pad output nibble, falling edge |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |

## Verification
The bench issues every kind with distinct addresses so that each address byte and nibble order is visible. Data transfers of several lengths, including zero, separate the length rule from the fixed two-byte register rule. Two identification reads with opposite strobe levels show whether the latency choice is sampled at all. Requests are issued back to back in `done` cycles, and a stray request is poked mid-transaction, to separate acceptance in the idle state from acceptance while busy.

// File: rtl/psq_pkg.sv
`timescale 1ns/1ps
package psq_pkg;

  localparam int ADDR_W = 32;

  typedef enum logic [2:0] {
    K_DRD = 3'd0,
    K_DWR = 3'd1,
    K_RRD = 3'd2,
    K_RWR = 3'd3,
    K_IDR = 3'd4
  } kind_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_CSS,
    PH_CMD,
    PH_ROW,
    PH_COL,
    PH_DUMMY,
    PH_DATA,
    PH_CSH,
    PH_DONE
  } phase_e;

endpackage

// File: rtl/psq_recipe.sv
`timescale 1ns/1ps
module psq_recipe
  import psq_pkg::*;
#(
  parameter int DATA_LAT = 28,
  parameter int REG_LAT  = 12,
  parameter int ID_LAT   = 8,
  parameter int CNT_W    = 9
) (
  input  kind_e            kind,
  input  logic             strobe,
  output logic [7:0]       cmd,
  output logic             sdr,
  output logic             is_rd,
  output logic             two_byte,
  output logic [CNT_W-1:0] lat
);

  always_comb begin
    cmd      = 8'hAA;
    sdr      = 1'b0;
    is_rd    = 1'b1;
    two_byte = 1'b0;
    lat      = CNT_W'(DATA_LAT);
    case (kind)
      K_DWR: begin
        cmd   = 8'h22;
        is_rd = 1'b0;
      end
      K_RRD: begin
        cmd      = 8'hCC;
        two_byte = 1'b1;
        lat      = CNT_W'(REG_LAT);
      end
      K_RWR: begin
        cmd      = 8'h66;
        is_rd    = 1'b0;
        two_byte = 1'b1;
        lat      = '0;
      end
      K_IDR: begin
        cmd      = 8'hE0;
        sdr      = 1'b1;
        two_byte = 1'b1;
        lat      = strobe ? CNT_W'(2 * ID_LAT) : CNT_W'(ID_LAT);
      end
      default: begin
        cmd = 8'hAA;
      end
    endcase
  end

endmodule

// File: rtl/psq_phase_ctrl.sv
`timescale 1ns/1ps
module psq_phase_ctrl
  import psq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  kind_e             req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [CNT_W-1:0]  lat,
  input  logic              two_byte,
  output phase_e            phase,
  output logic [CNT_W-1:0]  idx,
  output kind_e             kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              busy
);

  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] dly_q;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] data_last;
  logic             at_end;

  always_comb begin
    if (two_byte)            data_last = CNT_W'(1);
    else if (len_q == '0)    data_last = '0;
    else                     data_last = CNT_W'(len_q) - CNT_W'(1);
  end

  always_comb begin
    case (phase)
      PH_CMD, PH_ROW, PH_COL: last = CNT_W'(1);
      PH_DUMMY:               last = dly_q - CNT_W'(1);
      PH_DATA:                last = data_last;
      default:                last = '0;
    endcase
  end

  assign at_end = (idx == last);
  assign busy   = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      idx    <= '0;
      kind_q <= K_DRD;
      addr_q <= '0;
      len_q  <= '0;
      dly_q  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            kind_q <= req_kind;
            addr_q <= req_addr;
            len_q  <= req_len;
            idx    <= '0;
            phase  <= PH_CSS;
          end
        end
        PH_CSS: begin
          idx   <= '0;
          phase <= PH_CMD;
        end
        PH_CMD: begin
          if (at_end) begin
            idx   <= '0;
            phase <= PH_ROW;
          end else begin
            idx <= idx + CNT_W'(1);
          end
        end
        PH_ROW: begin
          if (at_end) begin
            idx   <= '0;
            phase <= PH_COL;
          end else begin
            idx <= idx + CNT_W'(1);
          end
        end
        PH_COL: begin
          if (at_end) begin
            idx   <= '0;
            dly_q <= lat;
            phase <= (lat == '0) ? PH_DATA : PH_DUMMY;
          end else begin
            idx <= idx + CNT_W'(1);
          end
        end
        PH_DUMMY: begin
          if (at_end) begin
            idx   <= '0;
            phase <= PH_DATA;
          end else begin
            idx <= idx + CNT_W'(1);
          end
        end
        PH_DATA: begin
          if (at_end) begin
            idx   <= '0;
            phase <= PH_CSH;
          end else begin
            idx <= idx + CNT_W'(1);
          end
        end
        PH_CSH:  phase <= PH_DONE;
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_KIND_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(kind_q) && $stable(addr_q))); // R2

endmodule

// File: rtl/psq_pad_drive.sv
`timescale 1ns/1ps
module psq_pad_drive
  import psq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase,
  input  logic              beat0,
  input  logic [7:0]        cmd,
  input  logic              sdr,
  input  logic              is_rd,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [7:0]        wr_data,
  input  logic [3:0]        dq_i_r,
  input  logic [3:0]        dq_i_f,
  output logic              cs_n,
  output logic              sck_en,
  output logic              dq_oe,
  output logic [3:0]        dq_o_r,
  output logic [3:0]        dq_o_f,
  output logic              done,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);

  logic [7:0] beat;
  logic       drive;
  logic       cap_q;

  always_comb begin
    beat  = 8'h00;
    drive = 1'b0;
    case (phase)
      PH_CMD: begin
        drive = 1'b1;
        if (sdr) beat = beat0 ? {cmd[7:4], cmd[7:4]} : {cmd[3:0], cmd[3:0]};
        else     beat = beat0 ? cmd : 8'h00;
      end
      PH_ROW: begin
        drive = 1'b1;
        beat  = beat0 ? addr_q[31:24] : addr_q[23:16];
      end
      PH_COL: begin
        drive = 1'b1;
        beat  = beat0 ? addr_q[15:8] : addr_q[7:0];
      end
      PH_DATA: begin
        drive = !is_rd;
        beat  = is_rd ? 8'h00 : wr_data;
      end
      default: begin
        beat  = 8'h00;
        drive = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n     <= 1'b1;
      sck_en   <= 1'b0;
      dq_oe    <= 1'b0;
      dq_o_r   <= 4'h0;
      dq_o_f   <= 4'h0;
      done     <= 1'b0;
      cap_q    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      cs_n     <= (phase == PH_IDLE) || (phase == PH_DONE);
      sck_en   <= (phase == PH_CMD) || (phase == PH_ROW) || (phase == PH_COL) ||
                  (phase == PH_DUMMY) || (phase == PH_DATA);
      dq_oe    <= drive;
      dq_o_r   <= beat[7:4];
      dq_o_f   <= beat[3:0];
      done     <= (phase == PH_DONE);
      cap_q    <= (phase == PH_DATA) && is_rd;
      rd_valid <= cap_q;
      if (cap_q) rd_data <= {dq_i_r, dq_i_f};
    end
  end

  AST_RD_NOT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!dq_oe && !cs_n && sck_en)); // R11

  AST_QUIET_PADS: assert property (@(posedge clk) disable iff (rst)
    !dq_oe |-> (dq_o_r == 4'h0 && dq_o_f == 4'h0)); // R10

endmodule

// File: rtl/psq_seq.sv
`timescale 1ns/1ps
module psq_seq
  import psq_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int DATA_LAT = 28,
  parameter int REG_LAT  = 12,
  parameter int ID_LAT   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [31:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        wr_data,
  output logic              wr_take,
  input  logic              lat_strobe,
  input  logic [3:0]        dq_i_r,
  input  logic [3:0]        dq_i_f,
  output logic              cs_n,
  output logic              sck_en,
  output logic              dq_oe,
  output logic [3:0]        dq_o_r,
  output logic [3:0]        dq_o_f,
  output logic              busy,
  output logic              done,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);

  localparam int LAT_AB  = (DATA_LAT > REG_LAT) ? DATA_LAT : REG_LAT;
  localparam int LAT_MAX = (LAT_AB > 2 * ID_LAT) ? LAT_AB : 2 * ID_LAT;
  localparam int SPAN    = (LAT_MAX > (1 << LEN_W)) ? LAT_MAX : (1 << LEN_W);
  localparam int CNT_W   = $clog2(SPAN + 1);

  phase_e            phase;
  logic [CNT_W-1:0]  idx;
  kind_e             kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        cmd;
  logic              sdr;
  logic              is_rd;
  logic              two_byte;
  logic [CNT_W-1:0]  lat;

  psq_recipe #(
    .DATA_LAT (DATA_LAT),
    .REG_LAT  (REG_LAT),
    .ID_LAT   (ID_LAT),
    .CNT_W    (CNT_W)
  ) u_recipe (
    .kind     (kind_q),
    .strobe   (lat_strobe),
    .cmd      (cmd),
    .sdr      (sdr),
    .is_rd    (is_rd),
    .two_byte (two_byte),
    .lat      (lat)
  );

  psq_phase_ctrl #(
    .LEN_W (LEN_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_kind  (kind_e'(req_kind)),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .lat       (lat),
    .two_byte  (two_byte),
    .phase     (phase),
    .idx       (idx),
    .kind_q    (kind_q),
    .addr_q    (addr_q),
    .busy      (busy)
  );

  psq_pad_drive u_pads (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .beat0    (idx == '0),
    .cmd      (cmd),
    .sdr      (sdr),
    .is_rd    (is_rd),
    .addr_q   (addr_q),
    .wr_data  (wr_data),
    .dq_i_r   (dq_i_r),
    .dq_i_f   (dq_i_f),
    .cs_n     (cs_n),
    .sck_en   (sck_en),
    .dq_oe    (dq_oe),
    .dq_o_r   (dq_o_r),
    .dq_o_f   (dq_o_f),
    .done     (done),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign wr_take = (phase == PH_DATA) && !is_rd;

  AST_CS_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> !sck_en); // R3

  AST_CLOCK_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |=> sck_en); // R3

  AST_DONE_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && $past(!cs_n))); // R3

  AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R3

  AST_DUMMY_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DUMMY) |=> (!dq_oe && sck_en && !cs_n)); // R10

  AST_REGWR_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_COL && kind_q == K_RWR) |=> (phase != PH_DUMMY)); // R8

  AST_TAKE_THEN_DRIVE: assert property (@(posedge clk) disable iff (rst)
    wr_take |=> (dq_oe && !cs_n)); // R12

endmodule

// File: tb/test_psq_seq.sv
`timescale 1ns/1ps
module test_psq_seq;

  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             req_valid;
  logic [2:0]       req_kind;
  logic [31:0]      req_addr;
  logic [LEN_W-1:0] req_len;
  logic [7:0]       wr_data;
  logic             wr_take;
  logic             lat_strobe;
  logic [3:0]       dq_i_r;
  logic [3:0]       dq_i_f;
  logic             cs_n;
  logic             sck_en;
  logic             dq_oe;
  logic [3:0]       dq_o_r;
  logic [3:0]       dq_o_f;
  logic             busy;
  logic             done;
  logic             rd_valid;
  logic [7:0]       rd_data;

  always #2.5 clk = ~clk;

  psq_seq i_psq_seq (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_kind (req_kind),
    .req_addr (req_addr), .req_len (req_len), .wr_data (wr_data),
    .wr_take (wr_take), .lat_strobe (lat_strobe), .dq_i_r (dq_i_r),
    .dq_i_f (dq_i_f), .cs_n (cs_n), .sck_en (sck_en), .dq_oe (dq_oe),
    .dq_o_r (dq_o_r), .dq_o_f (dq_o_f), .busy (busy), .done (done),
    .rd_valid (rd_valid), .rd_data (rd_data)
  );

  typedef struct packed {
    logic       cs_n;
    logic       sck;
    logic       oe;
    logic       done;
    logic       busy;
    logic       wt;
    logic       rdcyc;
    logic       rdv;
    logic [3:0] r;
    logic [3:0] f;
    logic [7:0] rin;
    logic [7:0] rdd;
    logic [3:0] tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   widx   = 0;
  int   rcnt   = 0;
  bit   finished = 0;

  function automatic logic [7:0] wpat(int i);
    return 8'(8'h3C + i * 29);
  endfunction

  function automatic logic [7:0] rpat(int i);
    return 8'(8'hC5 ^ (i * 7 + 1));
  endfunction

  function automatic exp_t idle_e();
    exp_t e = '0;
    e.cs_n = 1'b1;
    e.tag  = 4'd3;
    return e;
  endfunction

  task automatic chk(input bit ok, input int rq, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  // One cycle: compare at the falling edge, then drive memory-side inputs.
  task automatic step();
    exp_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else              e = idle_e();
    chk(cs_n == e.cs_n,    3, "cs_n (R3)",    cs_n,    e.cs_n);
    chk(sck_en == e.sck,   3, "sck_en (R3)",  sck_en,  e.sck);
    chk(done == e.done,    3, "done (R3)",    done,    e.done);
    chk(busy == e.busy,    3, "busy (R3)",    busy,    e.busy);
    chk(dq_oe == e.oe,    10, "dq_oe (R10)",  dq_oe,   e.oe);
    chk({dq_o_r, dq_o_f} == {e.r, e.f}, int'(e.tag), "pads",
        {dq_o_r, dq_o_f}, {e.r, e.f});
    chk(wr_take == e.wt,  12, "wr_take (R12)", wr_take, e.wt);
    chk(rd_valid == e.rdv, 11, "rd_valid (R11)", rd_valid, e.rdv);
    if (e.rdv) chk(rd_data == e.rdd, 11, "rd_data (R11)", rd_data, e.rdd);
    dq_i_r  = e.rdcyc ? e.rin[7:4] : 4'h0;
    dq_i_f  = e.rdcyc ? e.rin[3:0] : 4'h0;
    wr_data = wpat(widx);
    if (e.wt) widx++;
  endtask

  // Reference recipe: one expected entry per output cycle after acceptance.
  task automatic build(input logic [2:0] k, input logic [31:0] a,
                       input int len, input logic s);
    exp_t e;
    exp_t t;
    logic [7:0] c;
    logic [7:0] ab [4];
    int nd;
    int nb;
    int base_w = widx;
    bit rd = (k == 3'd0) || (k == 3'd2) || (k == 3'd4);
    e = '0; e.cs_n = 1'b1; e.busy = 1'b1; e.tag = 4'd3; q.push_back(e);
    e = '0; e.busy = 1'b1; e.tag = 4'd3; q.push_back(e);
    case (k)
      3'd0: c = 8'hAA;
      3'd1: c = 8'h22;
      3'd2: c = 8'hCC;
      3'd3: c = 8'h66;
      default: c = 8'hE0;
    endcase
    for (int i = 0; i < 2; i++) begin
      e = '0; e.busy = 1'b1; e.sck = 1'b1; e.oe = 1'b1;
      if (k == 3'd4) begin           // R9 single-rate command
        e.tag = 4'd9;
        e.r = (i == 0) ? 4'hE : 4'h0;
        e.f = e.r;
      end else begin                 // R4 double-rate command
        e.tag = 4'd4;
        e.r = (i == 0) ? c[7:4] : 4'h0;
        e.f = (i == 0) ? c[3:0] : 4'h0;
      end
      q.push_back(e);
    end
    ab[0] = a[31:24]; ab[1] = a[23:16]; ab[2] = a[15:8]; ab[3] = a[7:0];
    for (int i = 0; i < 4; i++) begin  // R5 address order
      e = '0; e.busy = 1'b1; e.sck = 1'b1; e.oe = 1'b1; e.tag = 4'd5;
      e.r = ab[i][7:4]; e.f = ab[i][3:0];
      q.push_back(e);
    end
    if (k <= 3'd1)      nd = 28;      // R6
    else if (k == 3'd2) nd = 12;      // R7
    else if (k == 3'd3) nd = 0;       // R8
    else                nd = s ? 16 : 8;  // R9
    for (int i = 0; i < nd; i++) begin
      e = '0; e.busy = 1'b1; e.sck = 1'b1;
      e.tag = (k <= 3'd1) ? 4'd6 : ((k == 3'd2) ? 4'd7 : 4'd9);
      q.push_back(e);
    end
    nb = (k <= 3'd1) ? ((len == 0) ? 1 : len) : 2;
    for (int j = 0; j < nb; j++) begin
      e = '0; e.busy = 1'b1; e.sck = 1'b1;
      if (rd) begin
        e.rdcyc = 1'b1; e.rin = rpat(rcnt); rcnt++; e.tag = 4'd11;
      end else begin
        t = q[q.size() - 1]; t.wt = 1'b1; q[q.size() - 1] = t;
        e.oe = 1'b1; e.tag = (k == 3'd3) ? 4'd8 : 4'd12;
        e.r = wpat(base_w + j) >> 4; e.f = wpat(base_w + j) & 8'h0F;
      end
      q.push_back(e);
    end
    e = '0; e.busy = 1'b1; e.tag = 4'd3; q.push_back(e);
    e = '0; e.cs_n = 1'b1; e.done = 1'b1; e.tag = 4'd3; q.push_back(e);
    for (int i = 0; i < q.size() - 1; i++) begin
      if (q[i].rdcyc) begin
        t = q[i + 1]; t.rdv = 1'b1; t.rdd = q[i].rin; q[i + 1] = t;
      end
    end
  endtask

  task automatic issue(input logic [2:0] k, input logic [31:0] a,
                       input int len, input logic s, input int poke);
    int n = 0;
    req_kind   = k;
    req_addr   = a;
    req_len    = LEN_W'(len);
    lat_strobe = s;
    req_valid  = 1'b1;
    build(k, a, len, s);
    step();
    req_valid = 1'b0;
    req_addr  = 32'hFFFF_FFFF;
    while (q.size() > 0) begin
      step();
      n++;
      if (n == poke) begin           // R2 stray request while busy
        req_valid = 1'b1;
        req_kind  = 3'd1;
        req_addr  = 32'h0BAD_F00D;
      end else begin
        req_valid = 1'b0;
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_kind = 3'd0; req_addr = '0;
    req_len = '0; wr_data = 8'h00; lat_strobe = 1'b0;
    dq_i_r = 4'h0; dq_i_f = 4'h0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1 && sck_en == 1'b0 && dq_oe == 1'b0, 1, "pads in reset",
        {cs_n, sck_en, dq_oe}, 3'b100);
    chk(busy == 1'b0 && done == 1'b0 && rd_valid == 1'b0 && wr_take == 1'b0,
        1, "status in reset", {busy, done, rd_valid, wr_take}, 0);
    rst = 1'b0;
    repeat (3) step();
    chk(cs_n == 1'b1 && busy == 1'b0, 1, "idle after reset (R1)",
        {cs_n, busy}, 2'b10);

    issue(3'd0, 32'h1234_5678, 4, 1'b0, -1);   // R6 data read
    issue(3'd1, 32'hA5C3_0F81, 3, 1'b0, -1);   // R6 R12 data write
    issue(3'd2, 32'h0000_0800, 0, 1'b0, -1);   // R7 register read
    issue(3'd3, 32'h0000_0800, 9, 1'b0, -1);   // R8 register write
    issue(3'd4, 32'h0000_0000, 0, 1'b0, -1);   // R9 strobe low
    issue(3'd4, 32'h4321_8765, 0, 1'b1, -1);   // R9 strobe high
    issue(3'd0, 32'hFEDC_BA98, 0, 1'b1, -1);   // R6 zero length
    issue(3'd1, 32'h0102_0304, 1, 1'b0, -1);   // R12 single byte
    issue(3'd2, 32'h7654_3210, 0, 1'b0, 5);    // R2 poke while busy
    repeat (40) step();                          // R2 nothing started
    issue(3'd3, 32'h00C0_FFEE, 0, 1'b1, 3);    // R2 R8 poke again
    repeat (10) step();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule